// File: doc/BRIEF.md
# Windowed Escalating Watchdog Timer

This block supervises software with a down-counter that advances on a slow tick from an independent oscillator. The tick arrives as a level from the slow domain and passes through a synchronizer with edge detection. Software keeps the counter from expiring by writing a refresh through a small register port. A refresh is accepted only when two conditions both hold. First, two key values must have been written in order to an unlock port. Second, at least a programmed minimum number of ticks must have passed since the last reload.

A refresh that comes too soon is a fault, and the block handles it exactly like an expiry. Each expiry or fault moves the block one stage up an escalation ladder. The first stage raises a non-maskable interrupt. The second asks for a warm reset. The third asks for a cold reset. Each reset request is a registered pulse held for a fixed number of ticks. A sticky status register records why each event happened. A test-mode input shortens the reload value and the window minimum so that production test runs quickly. Software can read the live counter at any time.

Top module: `wdog_window`

## Requirements
- R1: After rst_n the block reads as follows. The counter and the reload register read 64 and the window minimum reads 8. The control word (address 1) and the status word (address 4) read 0. nmi, warm_rst and cold_rst are low.
- R2: Each tick decrements the counter by one. On the tick that would take the counter from 1 to 0, the block expires: it loads the effective reload value and resets the elapsed-tick count.
- R3: A write to the refresh address (1) that is not preceded by the full unlock sequence leaves the counter unchanged. It sets status bit 4 (key error) and clears the unlock progress.
- R4: On the key address (0), the block advances progress from 0 to 1 on 0x5555 and from 1 to 2 on 0xAAAA. Any other key write clears progress to 0 and sets status bit 4.
- R5: A refresh with progress 2 and fewer elapsed ticks than the effective window minimum is an early fault. It escalates and reloads exactly like an expiry, and it sets status bit 3.
- R6: A refresh with progress 2 and at least the window minimum elapsed does the following. It reloads the counter, returns the stage to 0, drops nmi and clears the unlock progress.
- R7: Each expiry or early fault raises the stage by one, saturating at 3. Entering stage 1 sets status bit 0, and nmi stays high while the stage is non-zero. Entering stage 2 sets bit 1 and starts warm_rst. Entering or re-entering stage 3 sets bit 2 and starts cold_rst.
- R8: Once started, warm_rst and cold_rst stay high for exactly 16 ticks. They change only on tick cycles, except at their start.
- R9: Status bits remain set until rst_n or until software writes 1 to them at address 4. Bits written as 0 are kept, and the block's own reset outputs do not clear them.
- R10: The reload register (address 2) and the window-minimum register (address 3) take writes only until the first accepted refresh. After that, writes to them are ignored and both registers read back unchanged.
- R11: With test_mode high, the effective reload is the reload register shifted right by 3 (a result of 0 becomes 1). The effective window minimum is the minimum register shifted right by 3.
- R12: The control word at read address 1 holds the stage in bits 1:0, the unlock progress in bits 3:2 and the lock flag in bit 4. Read address 0 returns the live counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| tick_in | input | 1 | Slow-domain tick level; each rising edge is one tick |
| test_mode | input | 1 | Shortens reload and window minimum by a right shift |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address: 0 key, 1 refresh, 2 reload, 3 window min, 4 status clear |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address: 0 counter, 1 control, 2 reload, 3 window min, 4 status |
| rd_data | output | 16 | Combinational read data |
| nmi | output | 1 | Non-maskable interrupt, high while stage is non-zero |
| warm_rst | output | 1 | Stretched warm reset request |
| cold_rst | output | 1 | Stretched cold reset request |

## Verification
The assertions rely on three properties of the inputs. Only one write arrives per cycle. tick_in holds each level for at least three clock cycles, so each rising edge gives exactly one tick pulse. A refresh write never falls in the same cycle as a tick pulse. The stimulus meets these by making every operation a whole unit: a tick operation raises tick_in for four cycles and lowers it for four, while a write operation strobes wr_en for a single cycle and never overlaps a tick. Random choices select only the order of these units, the key values, the programmed values and the test-mode level. Directed steps cover the exact expiry tick, the whole escalation ladder, the stretch length and the lock.

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int CW         = 16,
  parameter int DEF_LOAD   = 64,
  parameter int DEF_WMIN   = 8,
  parameter int TEST_SHIFT = 3,
  parameter int RST_LEN    = 16,
  parameter logic [CW-1:0] KEY_A = CW'(16'h5555),
  parameter logic [CW-1:0] KEY_B = CW'(16'hAAAA)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_in,
  input  logic          test_mode,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  output logic          nmi,
  output logic          warm_rst,
  output logic          cold_rst
);
  localparam int SW = $clog2(RST_LEN + 1);
  localparam logic [2:0] A_KEY = 3'd0, A_KICK = 3'd1, A_LOAD = 3'd2, A_WMIN = 3'd3, A_STAT = 3'd4;

  logic [2:0]    tsync;
  logic [CW-1:0] cnt, elap, load_q, wmin_q, cnt_n, elap_n, eff_load, wmin_eff, shl;
  logic [1:0]    stage_q, stage_n, prog_q, prog_n;
  logic          locked_q, nmi_q, warm_q, cold_q;
  logic [4:0]    stat_q, stat_n, stat_set;
  logic [SW-1:0] wcnt, ccnt;

  wire tick    = tsync[1] & ~tsync[2];
  wire wr_key  = wr_en && wr_addr == A_KEY;
  wire wr_kick = wr_en && wr_addr == A_KICK;
  wire wr_load = wr_en && wr_addr == A_LOAD;
  wire wr_wmin = wr_en && wr_addr == A_WMIN;
  wire wr_stat = wr_en && wr_addr == A_STAT;

  assign shl      = test_mode ? (load_q >> TEST_SHIFT) : load_q;
  assign eff_load = (shl == '0) ? CW'(1) : shl;
  assign wmin_eff = test_mode ? (wmin_q >> TEST_SHIFT) : wmin_q;

  wire key_a_ok   = prog_q == 2'd0 && wr_data == KEY_A;
  wire key_b_ok   = prog_q == 2'd1 && wr_data == KEY_B;
  wire unlocked   = prog_q == 2'd2;
  wire kick_ok    = wr_kick && unlocked && elap >= wmin_eff;
  wire kick_early = wr_kick && unlocked && elap < wmin_eff;
  wire kick_bad   = wr_kick && !unlocked;
  wire expire     = tick && !wr_kick && cnt <= CW'(1);
  wire escalate   = expire || kick_early;
  wire key_err    = (wr_key && !key_a_ok && !key_b_ok) || kick_bad;

  always_comb begin
    stage_n = stage_q;
    if (escalate)     stage_n = (stage_q == 2'd3) ? 2'd3 : stage_q + 2'd1;
    else if (kick_ok) stage_n = 2'd0;

    cnt_n  = cnt;
    elap_n = elap;
    if (kick_ok || escalate) begin
      cnt_n  = eff_load;
      elap_n = '0;
    end else if (tick && !wr_kick) begin
      cnt_n  = cnt - CW'(1);
      elap_n = (&elap) ? elap : elap + CW'(1);
    end

    prog_n = prog_q;
    if (wr_key)       prog_n = key_a_ok ? 2'd1 : key_b_ok ? 2'd2 : 2'd0;
    else if (wr_kick) prog_n = 2'd0;

    stat_set = {key_err, kick_early,
                escalate && stage_n == 2'd3,
                escalate && stage_n == 2'd2,
                escalate && stage_n == 2'd1};
    stat_n = (stat_q & ~(wr_stat ? wr_data[4:0] : 5'd0)) | stat_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsync    <= '0;
      cnt      <= CW'(DEF_LOAD);
      elap     <= '0;
      load_q   <= CW'(DEF_LOAD);
      wmin_q   <= CW'(DEF_WMIN);
      stage_q  <= '0;
      prog_q   <= '0;
      locked_q <= 1'b0;
      stat_q   <= '0;
      nmi_q    <= 1'b0;
    end else begin
      tsync    <= {tsync[1:0], tick_in};
      cnt      <= cnt_n;
      elap     <= elap_n;
      stage_q  <= stage_n;
      prog_q   <= prog_n;
      stat_q   <= stat_n;
      nmi_q    <= stage_n != 2'd0;
      locked_q <= locked_q | kick_ok;
      if (wr_load && !locked_q) load_q <= wr_data;
      if (wr_wmin && !locked_q) wmin_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0; warm_q <= 1'b0;
      ccnt <= '0; cold_q <= 1'b0;
    end else begin
      if (escalate && stage_n == 2'd2) begin
        wcnt <= SW'(RST_LEN); warm_q <= 1'b1;
      end else if (tick && wcnt != '0) begin
        wcnt <= wcnt - SW'(1);
        if (wcnt == SW'(1)) warm_q <= 1'b0;
      end
      if (escalate && stage_n == 2'd3) begin
        ccnt <= SW'(RST_LEN); cold_q <= 1'b1;
      end else if (tick && ccnt != '0) begin
        ccnt <= ccnt - SW'(1);
        if (ccnt == SW'(1)) cold_q <= 1'b0;
      end
    end
  end

  assign nmi      = nmi_q;
  assign warm_rst = warm_q;
  assign cold_rst = cold_q;

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = cnt;
      3'd1:    rd_data = CW'({locked_q, prog_q, stage_q});
      3'd2:    rd_data = load_q;
      3'd3:    rd_data = wmin_q;
      3'd4:    rd_data = CW'(stat_q);
      default: rd_data = '0;
    endcase
  end

  p_bad_kick_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_KICK && prog_q != 2'd2) |=> cnt == $past(cnt));
  p_kick_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_KICK && prog_q == 2'd2 && elap >= wmin_eff) |=> (stage_q == 2'd0 && !nmi && prog_q == 2'd0));
  p_stage_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(wr_en && wr_addr == A_KICK)) |=> $stable(stage_q));
  p_cold_stage_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cold_rst) |-> stage_q == 2'd3);
  p_warm_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_rst && !tick) |=> warm_rst);
  p_cold_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cold_rst && !tick) |=> cold_rst);
  p_stat_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_STAT) |=> (stat_q & $past(stat_q)) == $past(stat_q));
  p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> (locked_q && load_q == $past(load_q) && wmin_q == $past(wmin_q)));
endmodule

// File: tb/wdog_window_tb.sv
`timescale 1ns/1ps
module wdog_window_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, tick_in = 1'b0, test_mode = 1'b0, wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic        nmi, warm_rst, cold_rst;

  always #2.5 clk = ~clk;

  wdog_window dut_i (.clk(clk), .rst_n(rst_n), .tick_in(tick_in), .test_mode(test_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .nmi(nmi), .warm_rst(warm_rst), .cold_rst(cold_rst));

  int checks = 0, errors = 0;
  int m_cnt, m_elap, m_load, m_wmin, m_stage, m_prog, m_locked, m_stat, m_wl, m_cl;
  bit m_tm;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic int eff_load();
    int v = m_tm ? (m_load >> 3) : m_load;
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int wmin_eff();
    return m_tm ? (m_wmin >> 3) : m_wmin;
  endfunction

  function automatic void m_event(bit early);
    m_stage = (m_stage == 3) ? 3 : m_stage + 1;
    m_cnt = eff_load();
    m_elap = 0;
    if (m_stage == 1) m_stat |= 1;
    if (m_stage == 2) begin m_stat |= 2; m_wl = 16; end
    if (m_stage == 3) begin m_stat |= 4; m_cl = 16; end
    if (early) m_stat |= 8;
  endfunction

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic check_all();
    logic [15:0] v;
    rd(3'd0, v); chk("R2 counter", 32'(v), 32'(m_cnt));
    rd(3'd1, v); chk("R12 control word", 32'(v), 32'((m_locked << 4) | (m_prog << 2) | m_stage));
    rd(3'd4, v); chk("R9 status", 32'(v), 32'(m_stat));
    rd(3'd2, v); chk("R10 reload reg", 32'(v), 32'(m_load));
    rd(3'd3, v); chk("R10 window reg", 32'(v), 32'(m_wmin));
    chk("R7 nmi", 32'(nmi), 32'(m_stage != 0));
    chk("R8 warm_rst", 32'(warm_rst), 32'(m_wl > 0));
    chk("R8 cold_rst", 32'(cold_rst), 32'(m_cl > 0));
  endtask

  task automatic do_tick();
    @(negedge clk); tick_in = 1'b1;
    repeat (4) @(negedge clk);
    tick_in = 1'b0;
    repeat (4) @(negedge clk);
    if (m_wl > 0) m_wl--;
    if (m_cl > 0) m_cl--;
    if (m_cnt <= 1) m_event(1'b0);
    else begin
      m_cnt--;
      if (m_elap < 65535) m_elap++;
    end
    check_all();
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      3'd0: if (m_prog == 0 && d == 16'h5555) m_prog = 1;
            else if (m_prog == 1 && d == 16'hAAAA) m_prog = 2;
            else begin m_prog = 0; m_stat |= 16; end
      3'd1: if (m_prog != 2) begin m_prog = 0; m_stat |= 16; end
            else begin
              m_prog = 0;
              if (m_elap >= wmin_eff()) begin
                m_stage = 0; m_cnt = eff_load(); m_elap = 0; m_locked = 1;
              end else m_event(1'b1);
            end
      3'd2: if (m_locked == 0) m_load = int'(d);
      3'd3: if (m_locked == 0) m_wmin = int'(d);
      3'd4: m_stat &= ~int'(d[4:0]);
      default: ;
    endcase
    check_all();
  endtask

  task automatic set_tm(bit t);
    @(negedge clk); test_mode = t; m_tm = t;
    check_all();
  endtask

  task automatic unlock_kick();
    wr(3'd0, 16'h5555);
    wr(3'd0, 16'hAAAA);
    wr(3'd1, 16'h0000);
  endtask

  initial begin
    logic [15:0] v;
    int r;
    void'($urandom(32'd1234));
    m_cnt = 64; m_elap = 0; m_load = 64; m_wmin = 8; m_stage = 0; m_prog = 0;
    m_locked = 0; m_stat = 0; m_wl = 0; m_cl = 0; m_tm = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();
    rd(3'd0, v); chk("R1 counter after reset", 32'(v), 32'd64);
    rd(3'd3, v); chk("R1 window min after reset", 32'(v), 32'd8);
    chk("R1 outputs after reset", {29'd0, nmi, warm_rst, cold_rst}, 32'd0);

    repeat (3) do_tick();
    rd(3'd0, v); chk("R2 three ticks", 32'(v), 32'd61);

    wr(3'd2, 16'd20);
    wr(3'd3, 16'd5);
    rd(3'd2, v); chk("R10 reload writable before lock", 32'(v), 32'd20);

    while (m_cnt > 1) do_tick();
    do_tick();
    rd(3'd0, v); chk("R2 reload on expiry", 32'(v), 32'd20);
    chk("R7 first expiry nmi", 32'(nmi), 32'd1);

    repeat (20) do_tick();
    chk("R7 second expiry warm", 32'(warm_rst), 32'd1);
    repeat (15) do_tick();
    chk("R8 warm still high at 15", 32'(warm_rst), 32'd1);
    do_tick();
    chk("R8 warm low after 16", 32'(warm_rst), 32'd0);
    repeat (4) do_tick();
    chk("R7 third expiry cold", 32'(cold_rst), 32'd1);
    rd(3'd4, v); chk("R7 status bits 2:0", 32'(v), 32'd7);
    repeat (20) do_tick();
    rd(3'd1, v); chk("R7 stage saturates", 32'(v & 16'h3), 32'd3);
    chk("R7 cold retriggered", 32'(cold_rst), 32'd1);

    wr(3'd0, 16'h5555);
    wr(3'd0, 16'h1234);
    rd(3'd1, v); chk("R4 wrong key clears progress", 32'((v >> 2) & 16'h3), 32'd0);
    rd(3'd4, v); chk("R4 key error flag", 32'(v[4]), 32'd1);
    wr(3'd4, 16'h0010);
    rd(3'd4, v); chk("R9 write-one clears only bit 4", 32'(v), 32'd7);

    rd(3'd0, v);
    wr(3'd1, 16'h0000);
    begin
      logic [15:0] v2;
      rd(3'd0, v2); chk("R3 stray refresh keeps counter", 32'(v2), 32'(v));
    end
    rd(3'd4, v); chk("R3 stray refresh flags error", 32'(v[4]), 32'd1);

    repeat (5) do_tick();
    wr(3'd0, 16'h5555);
    rd(3'd1, v); chk("R12 progress one", 32'((v >> 2) & 16'h3), 32'd1);
    wr(3'd0, 16'hAAAA);
    wr(3'd1, 16'h0000);
    rd(3'd1, v); chk("R6 valid refresh clears stage", 32'(v & 16'h3), 32'd0);
    chk("R6 nmi drops", 32'(nmi), 32'd0);
    rd(3'd0, v); chk("R6 counter reloaded", 32'(v), 32'd20);
    wr(3'd2, 16'd99);
    rd(3'd2, v); chk("R10 reload locked", 32'(v), 32'd20);

    unlock_kick();
    rd(3'd4, v); chk("R5 early flag", 32'(v[3]), 32'd1);
    chk("R5 early refresh raises nmi", 32'(nmi), 32'd1);

    set_tm(1'b1);
    unlock_kick();
    rd(3'd0, v); chk("R11 shortened reload", 32'(v), 32'd2);
    repeat (2) do_tick();
    rd(3'd1, v); chk("R11 quick expiry stage", 32'(v & 16'h3), 32'd1);
    set_tm(1'b0);

    for (int i = 0; i < 1400; i++) begin
      r = $urandom_range(0, 99);
      if (r < 50) do_tick();
      else if (r < 65) unlock_kick();
      else if (r < 72) wr(3'd1, 16'h0000);
      else if (r < 77) wr(3'd0, 16'($urandom_range(0, 65535)));
      else if (r < 82) wr(3'd0, 16'h5555);
      else if (r < 87) wr(3'd4, 16'($urandom_range(0, 31)));
      else if (r < 91) wr(3'($urandom_range(2, 3)), 16'($urandom_range(0, 40)));
      else if (r < 95) set_tm(1'($urandom_range(0, 1)));
      else wr(3'd0, 16'hAAAA);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule